// File: doc/BRIEF.md
# SDRAM Burst Request Arbiter

This block lets two independent streams share one single-port SDRAM controller. A producer side (audio or camera) hands over a start address on a write-address handshake port and then a burst of words on a write-data port. A consumer side (video) hands over a start address on a read-address handshake port and receives the burst back on a read-data port. Every design-side port uses a valid/ready handshake. A word or address moves only in a cycle where both valid and ready are high.

On the controller side the block issues single-cycle read or write request strobes. It drives the latched burst address and, for writes, drives the buffered words with the bus output enable raised. Read words arrive qualified by a valid strobe and go into an internal buffer, which the read-data port drains at the consumer's pace. No request leaves the block before the controller reports that initialisation is complete, or while the controller reports that it is busy.

When both address ports are offered in the same idle cycle, one of them is granted by a fixed-plus-alternation rule. The read port wins unless the previously granted burst was a read, in which case the write port wins. This keeps the video path fed and still stops writes from starving.

Top module: `sdram_burst_arbiter`

## Requirements
- R1: `ctl_rd_req` and `ctl_wr_req` are each high for exactly one cycle per burst and are never high together.
- R2: The address driven on `ctl_addr` during a request is the address accepted for that burst, unchanged. It is packed as row (upper 13 bits), bank (next 2 bits) and column (lower 9 bits).
- R3: No request is issued unless `ctl_init_done` was high at the clock edge that launched it.
- R4: No request is issued unless `ctl_idle` was high at the clock edge that launched it.
- R5: Each read word is captured only in a cycle where `ctl_rdata_vld` is high. Words leave on `rd_data` in arrival order. While `rd_data_valid` is high and `rd_data_ready` is low, the valid flag and the data hold steady.
- R6: After a write address is accepted, `wr_data_ready` is high until exactly BURST_LEN words have been taken, and is low at all other times. The write request follows only once the whole burst is buffered. Word k appears on `ctl_wdata` k cycles after the request cycle (word 0 in the request cycle itself). `ctl_oe` is high for exactly those BURST_LEN cycles and low otherwise.
- R7: When both address ports are valid in an idle cycle, the read port is granted unless the last granted burst was a read, in which case the write port is granted.
- R8: An address-port ready is high only while the block is idle, and at most one address-port ready is high in any cycle.
- R9: A stalled read consumer loses no data: a completed burst is held in the read buffer. A further read request waits until the buffer has room for a full burst.
- R10: After reset, all request strobes, `ctl_oe`, `rd_data_valid`, `wr_data_ready` and both address-port readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_init_done | input | 1 | Controller has finished initialisation |
| ctl_idle | input | 1 | Controller is not servicing a request |
| ctl_rd_req | output | 1 | One-cycle read burst request |
| ctl_wr_req | output | 1 | One-cycle write burst request |
| ctl_addr | output | 24 | Burst start address {row, bank, column} |
| ctl_oe | output | 1 | Enable for driving write data onto the shared bus |
| ctl_wdata | output | 32 | Write word toward the controller |
| ctl_rdata | input | 32 | Read word from the controller |
| ctl_rdata_vld | input | 1 | `ctl_rdata` holds a valid word |
| rd_addr | input | 24 | Read burst start address |
| rd_addr_valid | input | 1 | Read address offered |
| rd_addr_ready | output | 1 | Read address accepted this cycle if valid |
| rd_data | output | 32 | Read word toward the consumer |
| rd_data_valid | output | 1 | `rd_data` holds a word |
| rd_data_ready | input | 1 | Consumer takes the word |
| wr_addr | input | 24 | Write burst start address |
| wr_addr_valid | input | 1 | Write address offered |
| wr_addr_ready | output | 1 | Write address accepted this cycle if valid |
| wr_data | input | 32 | Write word from the producer |
| wr_data_valid | input | 1 | Write word offered |
| wr_data_ready | output | 1 | Write word accepted this cycle if valid |

## Verification
Address-port readies respond combinationally to the offered valids, so the bench drives inputs on the falling edge and samples ready one time unit later to decide whether the coming rising edge transfers. A request strobe rises one edge after the wait state sees init-done, controller-idle and buffer room, and it is sampled on the following falling edge. Write words are due on that same falling edge and on each of the next BURST_LEN-1 falling edges, and they are compared there together with `ctl_oe`. A read word captured at a rising edge is visible on `rd_data` after that edge, so the consumer model compares each handshaken word against its queue of expected words, and the stall check looks one cycle after every refused word.

// File: rtl/sdram_arb_pkg.sv
package sdram_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WFILL,
      ST_WWAIT,
      ST_WPULSE,
      ST_WDRIVE,
      ST_RWAIT,
      ST_RPULSE,
      ST_RCOLLECT
   } arb_state_t;
endpackage

// File: rtl/sdram_arb_pick.sv
module sdram_arb_pick #(
   parameter bit READ_FIRST = 1'b1
) (
   input  logic en,
   input  logic rd_v,
   input  logic wr_v,
   input  logic last_rd,
   output logic gnt_rd,
   output logic gnt_wr
);
   logic rd_wins_tie;

   generate
      if (READ_FIRST) begin : g_read_first
         assign rd_wins_tie = !last_rd;
      end else begin : g_write_first
         assign rd_wins_tie = 1'b0;
      end
   endgenerate

   always_comb begin
      gnt_rd = 1'b0;
      gnt_wr = 1'b0;
      if (en) begin
         if (rd_v && wr_v) begin
            gnt_rd = rd_wins_tie;
            gnt_wr = !rd_wins_tie;
         end else begin
            gnt_rd = rd_v;
            gnt_wr = wr_v;
         end
      end
   end
endmodule

// File: rtl/sdram_arb_wbuf.sv
module sdram_arb_wbuf #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= din;
   end

   assign dout = mem[ridx];
endmodule

// File: rtl/sdram_arb_rfifo.sv
module sdram_arb_rfifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int ROOM   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              not_empty,
   output logic              has_room
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic [CW-1:0]     count;

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) begin
            mem[wptr] <= din;
            wptr      <= wptr + 1'b1;
         end
         if (pop) rptr <= rptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign dout      = mem[rptr];
   assign not_empty = (count != '0);
   assign has_room  = (CW'(DEPTH) - count) >= CW'(ROOM);
endmodule

// File: rtl/sdram_burst_arbiter.sv
module sdram_burst_arbiter
   import sdram_arb_pkg::*;
#(
   parameter int ROW_W      = 13,
   parameter int BANK_W     = 2,
   parameter int COL_W      = 9,
   parameter int ADDR_W     = ROW_W + BANK_W + COL_W,
   parameter int DATA_W     = 32,
   parameter int BURST_LEN  = 8,
   parameter int RBUF_DEPTH = 8,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_init_done,
   input  logic              ctl_idle,
   output logic              ctl_rd_req,
   output logic              ctl_wr_req,
   output logic [ADDR_W-1:0] ctl_addr,
   output logic              ctl_oe,
   output logic [DATA_W-1:0] ctl_wdata,
   input  logic [DATA_W-1:0] ctl_rdata,
   input  logic              ctl_rdata_vld,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_addr_valid,
   output logic              rd_addr_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_valid,
   input  logic              rd_data_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_addr_valid,
   output logic              wr_addr_ready,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_data_valid,
   output logic              wr_data_ready
);
   localparam int BEAT_W = $clog2(BURST_LEN);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

   generate
      if (ADDR_W != ROW_W + BANK_W + COL_W) begin : g_bad_addr
         $error("address width must equal row + bank + column widths");
      end
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("burst length must be a power of two of at least 2");
      end
      if (RBUF_DEPTH < BURST_LEN || (RBUF_DEPTH & (RBUF_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("read buffer must be a power of two holding a full burst");
      end
   endgenerate

   arb_state_t        state;
   logic [BEAT_W-1:0] beat;
   logic [ADDR_W-1:0] addr_q;
   logic              last_rd;
   logic              gnt_rd, gnt_wr;
   logic              fill_fire, cap, rbuf_room, pop;
   logic              ctl_ready;

   sdram_arb_pick #(.READ_FIRST(READ_FIRST)) u_pick (
      .en      (state == ST_IDLE),
      .rd_v    (rd_addr_valid),
      .wr_v    (wr_addr_valid),
      .last_rd (last_rd),
      .gnt_rd  (gnt_rd),
      .gnt_wr  (gnt_wr)
   );

   assign rd_addr_ready = gnt_rd;
   assign wr_addr_ready = gnt_wr;
   assign wr_data_ready = (state == ST_WFILL);
   assign fill_fire     = wr_data_valid && wr_data_ready;
   assign cap           = ctl_rdata_vld && (state == ST_RPULSE || state == ST_RCOLLECT);
   assign pop           = rd_data_valid && rd_data_ready;
   assign ctl_ready     = ctl_init_done && ctl_idle;

   assign ctl_rd_req = (state == ST_RPULSE);
   assign ctl_wr_req = (state == ST_WPULSE);
   assign ctl_oe     = (state == ST_WPULSE) || (state == ST_WDRIVE);
   assign ctl_addr   = addr_q;

   sdram_arb_wbuf #(.DATA_W(DATA_W), .WORDS(BURST_LEN), .IDX_W(BEAT_W)) u_wbuf (
      .clk  (clk),
      .we   (fill_fire),
      .widx (beat),
      .din  (wr_data),
      .ridx ((state == ST_WDRIVE) ? beat : '0),
      .dout (ctl_wdata)
   );

   sdram_arb_rfifo #(.DATA_W(DATA_W), .DEPTH(RBUF_DEPTH), .ROOM(BURST_LEN)) u_rbuf (
      .clk       (clk),
      .rst       (rst),
      .push      (cap),
      .din       (ctl_rdata),
      .pop       (pop),
      .dout      (rd_data),
      .not_empty (rd_data_valid),
      .has_room  (rbuf_room)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         beat    <= '0;
         addr_q  <= '0;
         last_rd <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               beat <= '0;
               if (gnt_wr) begin
                  addr_q  <= wr_addr;
                  last_rd <= 1'b0;
                  state   <= ST_WFILL;
               end else if (gnt_rd) begin
                  addr_q  <= rd_addr;
                  last_rd <= 1'b1;
                  state   <= ST_RWAIT;
               end
            end
            ST_WFILL: if (fill_fire) begin
               beat <= beat + 1'b1;
               if (beat == LAST_BEAT) state <= ST_WWAIT;
            end
            ST_WWAIT:  if (ctl_ready) state <= ST_WPULSE;
            ST_WPULSE: begin
               beat  <= BEAT_W'(1);
               state <= ST_WDRIVE;
            end
            ST_WDRIVE: begin
               beat <= beat + 1'b1;
               if (beat == LAST_BEAT) state <= ST_IDLE;
            end
            ST_RWAIT: if (ctl_ready && rbuf_room) state <= ST_RPULSE;
            ST_RPULSE: begin
               if (cap) beat <= beat + 1'b1;
               state <= ST_RCOLLECT;
            end
            ST_RCOLLECT: if (cap) begin
               beat <= beat + 1'b1;
               if (beat == LAST_BEAT) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdram_arb_checker.sv
module sdram_arb_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              ctl_init_done,
   input logic              ctl_idle,
   input logic              ctl_rd_req,
   input logic              ctl_wr_req,
   input logic              ctl_oe,
   input logic              rd_addr_ready,
   input logic              wr_addr_ready,
   input logic              wr_data_ready,
   input logic              rd_data_valid,
   input logic              rd_data_ready,
   input logic [DATA_W-1:0] rd_data
);
   assert_rd_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      ctl_rd_req |=> !ctl_rd_req);
   assert_wr_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      ctl_wr_req |=> !ctl_wr_req);
   assert_req_excl_R1: assert property (@(posedge clk) disable iff (rst)
      !(ctl_rd_req && ctl_wr_req));
   assert_init_gate_R3: assert property (@(posedge clk) disable iff (rst)
      ($rose(ctl_rd_req) || $rose(ctl_wr_req)) |-> $past(ctl_init_done));
   assert_idle_gate_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(ctl_rd_req) || $rose(ctl_wr_req)) |-> $past(ctl_idle));
   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_data_valid && !rd_data_ready) |=> (rd_data_valid && $stable(rd_data)));
   assert_oe_on_wr_R6: assert property (@(posedge clk) disable iff (rst)
      ctl_wr_req |-> ctl_oe);
   assert_oe_off_rd_R6: assert property (@(posedge clk) disable iff (rst)
      (ctl_rd_req || wr_data_ready) |-> !ctl_oe);
   assert_one_port_R8: assert property (@(posedge clk) disable iff (rst)
      !(rd_addr_ready && wr_addr_ready));
endmodule

bind sdram_burst_arbiter sdram_arb_checker #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .ctl_init_done (ctl_init_done),
   .ctl_idle      (ctl_idle),
   .ctl_rd_req    (ctl_rd_req),
   .ctl_wr_req    (ctl_wr_req),
   .ctl_oe        (ctl_oe),
   .rd_addr_ready (rd_addr_ready),
   .wr_addr_ready (wr_addr_ready),
   .wr_data_ready (wr_data_ready),
   .rd_data_valid (rd_data_valid),
   .rd_data_ready (rd_data_ready),
   .rd_data       (rd_data)
);

// File: tb/sdram_burst_arbiter_bench.sv
module sdram_burst_arbiter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BL = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ctl_init_done = 1'b0;
   logic        ctl_idle = 1'b1;
   logic        ctl_rd_req, ctl_wr_req, ctl_oe;
   logic [23:0] ctl_addr;
   logic [31:0] ctl_wdata;
   logic [31:0] ctl_rdata = '0;
   logic        ctl_rdata_vld = 1'b0;
   logic [23:0] rd_addr = '0;
   logic        rd_addr_valid = 1'b0;
   logic        rd_addr_ready;
   logic [31:0] rd_data;
   logic        rd_data_valid;
   logic        rd_data_ready = 1'b0;
   logic [23:0] wr_addr = '0;
   logic        wr_addr_valid = 1'b0;
   logic        wr_addr_ready;
   logic [31:0] wr_data = '0;
   logic        wr_data_valid = 1'b0;
   logic        wr_data_ready;

   int checks = 0;
   int errors = 0;
   int reqs = 0;
   bit force_busy = 1'b0;
   bit stall = 1'b0;
   bit calm = 1'b1;
   bit gaps = 1'b0;

   logic [31:0] rexp[$];
   logic [31:0] wexp[$];
   logic [23:0] raq[$];
   logic [23:0] waq[$];
   bit          svc_log[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_burst_arbiter u_sdram_burst_arbiter (.*);

   function automatic logic [23:0] mk_addr(input int row, input int bank, input int col);
      return {row[12:0], bank[1:0], col[8:0]};
   endfunction

   function automatic logic [31:0] rd_word(input logic [23:0] a, input int k);
      return {k[7:0] ^ 8'hC3, a};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // controller model
   int rd_left = 0, rd_k = 0, wr_left = 0;
   logic [23:0] rd_a = '0;
   always @(negedge clk) begin
      if (!rst) begin
         if (ctl_rd_req) begin
            reqs++;
            svc_log.push_back(1'b0);
            rd_left = BL; rd_k = 0; rd_a = ctl_addr;
            if (raq.size() > 0) check(ctl_addr == raq[0], "R2 read addr", 32'(ctl_addr), 32'(raq[0]));
            else check(0, "R2 unexpected read", 32'(ctl_addr), 0);
            if (raq.size() > 0) void'(raq.pop_front());
         end
         if (ctl_wr_req) begin
            reqs++;
            svc_log.push_back(1'b1);
            wr_left = BL;
            if (waq.size() > 0) check(ctl_addr == waq[0], "R2 write addr", 32'(ctl_addr), 32'(waq[0]));
            else check(0, "R2 unexpected write", 32'(ctl_addr), 0);
            if (waq.size() > 0) void'(waq.pop_front());
         end
         if (wr_left > 0) begin
            check(ctl_oe == 1'b1, "R6 oe during burst", 32'(ctl_oe), 1);
            if (wexp.size() > 0) begin
               check(ctl_wdata == wexp[0], "R6 write word", ctl_wdata, wexp[0]);
               void'(wexp.pop_front());
            end else check(0, "R6 write word missing", ctl_wdata, 0);
            wr_left--;
         end else if (ctl_oe) begin
            check(0, "R6 oe outside burst", 32'(ctl_oe), 0);
         end
         ctl_rdata_vld = 1'b0;
         if (rd_left > 0 && (!gaps || ($urandom % 4) != 0)) begin
            ctl_rdata_vld = 1'b1;
            ctl_rdata = rd_word(rd_a, rd_k);
            rd_k++; rd_left--;
         end
         ctl_idle = !(rd_left > 0 || wr_left > 0 || force_busy);
      end
   end

   // read consumer model
   bit prev_hold = 1'b0;
   logic [31:0] prev_data = '0;
   always @(negedge clk) begin
      if (!rst) begin
         if (prev_hold) begin
            check(rd_data_valid && rd_data == prev_data, "R5 hold while stalled", rd_data, prev_data);
         end
         rd_data_ready = stall ? 1'b0 : (calm ? 1'b1 : (($urandom % 4) != 0));
         #1;
         prev_hold = rd_data_valid && !rd_data_ready;
         prev_data = rd_data;
         if (rd_data_valid && rd_data_ready) begin
            if (rexp.size() > 0) begin
               check(rd_data == rexp[0], "R5 read word order", rd_data, rexp[0]);
               void'(rexp.pop_front());
            end else check(0, "R5 unexpected read word", rd_data, 0);
         end
      end
   end

   task automatic do_read(input logic [23:0] a);
      rd_addr = a; rd_addr_valid = 1'b1;
      forever begin
         #1;
         if (rd_addr_ready) break;
         @(negedge clk);
      end
      raq.push_back(a);
      for (int k = 0; k < BL; k++) rexp.push_back(rd_word(a, k));
      @(negedge clk);
      rd_addr_valid = 1'b0;
   endtask

   task automatic do_write(input logic [23:0] a);
      wr_addr = a; wr_addr_valid = 1'b1;
      forever begin
         #1;
         if (wr_addr_ready) break;
         @(negedge clk);
      end
      waq.push_back(a);
      @(negedge clk);
      wr_addr_valid = 1'b0;
      for (int k = 0; k < BL; k++) begin
         while (gaps && ($urandom % 3) == 0) begin
            wr_data_valid = 1'b0;
            @(negedge clk);
         end
         wr_data = $urandom;
         wr_data_valid = 1'b1;
         forever begin
            #1;
            if (wr_data_ready) break;
            @(negedge clk);
         end
         wexp.push_back(wr_data);
         @(negedge clk);
      end
      wr_data_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      int n = 0;
      while ((rexp.size() + wexp.size() + raq.size() + waq.size()) != 0 && n < 4000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      check(rexp.size() == 0 && wexp.size() == 0, req, 32'(rexp.size() + wexp.size()), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int base;
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk); #1;
      // R10 reset state
      check(!ctl_rd_req && !ctl_wr_req, "R10 requests low", {30'd0, ctl_rd_req, ctl_wr_req}, 0);
      check(!ctl_oe, "R10 oe low", 32'(ctl_oe), 0);
      check(!rd_data_valid && !wr_data_ready, "R10 data handshakes low", {30'd0, rd_data_valid, wr_data_ready}, 0);
      check(!rd_addr_ready && !wr_addr_ready, "R10 R8 address readies low", {30'd0, rd_addr_ready, wr_addr_ready}, 0);
      @(negedge clk);

      // R3: init gating
      do_read(mk_addr(100, 1, 8));
      repeat (20) @(negedge clk);
      check(reqs == 0, "R3 no request before init", 32'(reqs), 0);
      ctl_init_done = 1'b1;
      drain("R3 read burst after init");

      // R4 and R6: busy gating, extra data refused
      force_busy = 1'b1;
      base = reqs;
      do_write(mk_addr(8191, 3, 511));
      wr_data_valid = 1'b1; wr_data = 32'hDEAD_BEEF;
      #1;
      check(!wr_data_ready, "R6 no ready after full burst", 32'(wr_data_ready), 0);
      @(negedge clk);
      wr_data_valid = 1'b0;
      repeat (15) @(negedge clk);
      check(reqs == base, "R4 no request while busy", 32'(reqs), 32'(base));
      force_busy = 1'b0;
      drain("R6 write burst drained");

      // R7: tie with read, alternation afterwards
      base = svc_log.size();
      fork
         begin do_read(mk_addr(5, 0, 0)); do_read(mk_addr(6, 2, 16)); end
         do_write(mk_addr(7, 1, 32));
      join
      drain("R7 tie bursts drained");
      check(svc_log.size() == base + 3, "R7 burst count", 32'(svc_log.size()), 32'(base + 3));
      if (svc_log.size() == base + 3) begin
         check(svc_log[base] == 1'b0, "R7 read wins tie", 32'(svc_log[base]), 0);
         check(svc_log[base+1] == 1'b1, "R7 write after read", 32'(svc_log[base+1]), 1);
         check(svc_log[base+2] == 1'b0, "R7 read last", 32'(svc_log[base+2]), 0);
      end

      // R9: stalled consumer
      stall = 1'b1;
      do_read(mk_addr(300, 2, 100));
      repeat (30) @(negedge clk);
      check(rd_data_valid, "R9 data held while stalled", 32'(rd_data_valid), 1);
      base = reqs;
      do_read(mk_addr(301, 3, 200));
      repeat (20) @(negedge clk);
      check(reqs == base, "R9 read waits for room", 32'(reqs), 32'(base));
      stall = 1'b0;
      drain("R9 stalled bursts delivered");

      // random mix
      gaps = 1'b1; calm = 1'b0;
      for (int i = 0; i < 40; i++) begin
         int op = $urandom % 3;
         logic [23:0] a1 = mk_addr($urandom % 8192, $urandom % 4, $urandom % 512);
         logic [23:0] a2 = mk_addr($urandom % 8192, $urandom % 4, $urandom % 512);
         if (op == 0) do_read(a1);
         else if (op == 1) do_write(a1);
         else fork do_read(a1); do_write(a2); join
      end
      drain("R5 R6 random traffic drained");
      check(!ctl_oe && !wr_data_ready, "R8 idle after traffic", {30'd0, ctl_oe, wr_data_ready}, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule